// File: doc/BRIEF.md
# Single-Wire Slave Bit-Timing Engine

This block is the timing front end of a slave on a single-wire, open-drain bus. It samples the bus level through a synchronizer and drives an active-high pull-down enable. It turns the master's low pulses into three kinds of event. A long low pulse is a bus reset, which the block answers with its own presence pulse. A short pulse during a write slot carries one received bit. A slot in which the upper layer has a bit to return is a read slot, and for a zero the block stretches the low time. All timing comes from a cycle counter scaled by a cycles-per-microsecond parameter.

Two speeds are supported. The `od_mode` input picks fast timing, and each slot latches the speed at its falling edge. Toward the addressing layer the block raises a one-cycle strobe with each received bit and a strobe when a read slot starts. A reset is reported as long or short; the addressing layer uses this to decide whether to drop fast mode. At standard speed a hold-off window after each rising edge hides falling glitches. The window does not apply at fast speed.

Top module: `ow_bit_engine`

## Requirements
- R1: After reset, `pull_dn`, `rx_valid`, `tx_req`, `rst_short` and `rst_long` are all 0. The bus input passes through a two-flop synchronizer before any decision is made on it.
- R2: A slot that starts with `tx_en` low is a write slot. It produces exactly one `rx_valid` pulse, and `rx_bit` is the line level 30 µs (standard) or 3 µs (fast) after the falling edge. A low time of at most 15 µs / 2 µs gives 1, and one of at least 60 µs / 6 µs gives 0.
- R3: A slot that starts with `tx_en` high is a read slot. It gives one `tx_req` pulse and no `rx_valid`. If `tx_bit` is 0, `pull_dn` is high for exactly 30 µs (standard) or 3 µs (fast) of clock cycles. If `tx_bit` is 1, `pull_dn` stays low.
- R4: A low time of at least 120 µs (standard) or 16 µs (fast) is a reset, and it is reported when the line rises again. A shorter low time is an ordinary slot; for example, 100 µs at standard speed is a write-zero.
- R5: A reset whose low time is at least 480 µs pulses `rst_long`. Any shorter reset pulses `rst_short`. At fast speed this includes the 80 to 480 µs band, so fast mode is kept there.
- R6: After a reset, `pull_dn` rises 20 µs (standard) or 3 µs (fast) after the line rises, plus three cycles of synchronizer and decision latency. It then stays high for 120 µs (standard) or 12 µs (fast) of cycles. The block's own presence pulse does not start a slot.
- R7: The presence pulse uses standard timing after a long reset, even when `od_mode` is high. After a short reset it uses the speed latched at the reset's falling edge.
- R8: At standard speed only, a falling edge within `HOLDOFF_NS` after the most recent rise of the line is ignored: it gives no slot and no strobe. The same falling edge at fast speed starts a slot, and so does a falling edge at standard speed after the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_in | input | 1 | Raw bus level (1 = released) |
| od_mode | input | 1 | 1 selects fast timing for the next slot |
| tx_en | input | 1 | Next slot is a read slot |
| tx_bit | input | 1 | Bit to return in a read slot |
| pull_dn | output | 1 | Pull-down enable for the open-drain driver |
| rx_valid | output | 1 | One-cycle strobe with a received bit |
| rx_bit | output | 1 | Received bit, valid with `rx_valid` |
| tx_req | output | 1 | One-cycle strobe at the start of a read slot |
| rst_short | output | 1 | Strobe: reset shorter than 480 µs detected |
| rst_long | output | 1 | Strobe: reset of 480 µs or more detected |

## Verification
The case that is hardest to reach from the ports is a falling glitch inside the standard-speed hold-off window. The window only opens on a rise that happens while the block is idle or watching a long low. The stimulus therefore ends a write-zero slot and pulls the line low again two cycles after release, while the window is still open. It then repeats the same glitch at fast speed, and once more at standard speed after the window has closed, to show that only the first is hidden. Fast-mode resets of 500 µs are also driven, to confirm that the presence pulse falls back to standard timing.

// File: rtl/ow_pkg.sv
`timescale 1ns/1ps
package ow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_LOW,
        ST_PDH,
        ST_PDL,
        ST_REC
    } ow_state_e;

    function automatic int us_to_cyc(input int us, input int cyc_per_us);
        return us * cyc_per_us;
    endfunction

    function automatic int ns_to_cyc(input int ns, input int cyc_per_us);
        return (ns * cyc_per_us + 999) / 1000;
    endfunction

endpackage

// File: rtl/ow_sync.sv
`timescale 1ns/1ps
module ow_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign sh_d[g] = din;
        end else begin : g_rest
            assign sh_d[g] = sh_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/ow_holdoff.sv
`timescale 1ns/1ps
module ow_holdoff #(
    parameter int HOLD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic od_mode,
    output logic line_m
);
    localparam int  HW     = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam bit  HAS_HO = (HOLD_CYC > 0);
    localparam logic [HW-1:0] C_LAST = (HOLD_CYC > 0) ? HW'(HOLD_CYC - 1) : '0;

    typedef struct packed {
        logic          prev;
        logic          act;
        logic [HW-1:0] cnt;
    } ho_t;

    ho_t ho_d, ho_q;

    always_comb begin
        ho_d      = ho_q;
        ho_d.prev = line_s;
        if (line_s && !ho_q.prev) begin
            ho_d.cnt = '0;
            ho_d.act = HAS_HO;
        end else if (ho_q.act) begin
            if (ho_q.cnt == C_LAST) ho_d.act = 1'b0;
            else                    ho_d.cnt = ho_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ho_q.prev <= 1'b1;
            ho_q.act  <= 1'b0;
            ho_q.cnt  <= '0;
        end else begin
            ho_q <= ho_d;
        end
    end

    // Window only hides falls at standard speed
    assign line_m = line_s | (ho_q.act & ~od_mode);

    if (HOLD_CYC > 0) begin : g_chk
        // R8: the cycle after a rise at standard speed cannot show a fall
        p_quiet_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(line_s) && !od_mode) |=> (line_m || od_mode));
    end
endmodule

// File: rtl/ow_slot_fsm.sv
`timescale 1ns/1ps
module ow_slot_fsm #(
    parameter int CYC_PER_US  = 100,
    parameter int SAMP_STD_US = 30,
    parameter int SAMP_OD_US  = 3,
    parameter int HOLD_STD_US = 30,
    parameter int HOLD_OD_US  = 3,
    parameter int RST_STD_US  = 120,
    parameter int RST_OD_US   = 16,
    parameter int LONG_US     = 480,
    parameter int PDH_STD_US  = 20,
    parameter int PDH_OD_US   = 3,
    parameter int PDL_STD_US  = 120,
    parameter int PDL_OD_US   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic line_m,
    input  logic od_mode,
    input  logic tx_en,
    input  logic tx_bit,
    output logic pull_dn,
    output logic rx_valid,
    output logic rx_bit,
    output logic tx_req,
    output logic rst_short,
    output logic rst_long
);
    import ow_pkg::*;

    localparam int LONG_CYC = us_to_cyc(LONG_US, CYC_PER_US);
    localparam int PDL_CYC  = us_to_cyc(PDL_STD_US, CYC_PER_US);
    localparam int TOP_CYC  = (LONG_CYC > PDL_CYC) ? LONG_CYC : PDL_CYC;
    localparam int CW       = $clog2(TOP_CYC + 2);

    localparam logic [CW-1:0] C_SAMP_S = CW'(us_to_cyc(SAMP_STD_US, CYC_PER_US));
    localparam logic [CW-1:0] C_SAMP_O = CW'(us_to_cyc(SAMP_OD_US,  CYC_PER_US));
    localparam logic [CW-1:0] C_HOLD_S = CW'(us_to_cyc(HOLD_STD_US, CYC_PER_US));
    localparam logic [CW-1:0] C_HOLD_O = CW'(us_to_cyc(HOLD_OD_US,  CYC_PER_US));
    localparam logic [CW-1:0] C_RST_S  = CW'(us_to_cyc(RST_STD_US,  CYC_PER_US));
    localparam logic [CW-1:0] C_RST_O  = CW'(us_to_cyc(RST_OD_US,   CYC_PER_US));
    localparam logic [CW-1:0] C_LONG   = CW'(LONG_CYC);
    localparam logic [CW-1:0] C_PDH_S  = CW'(us_to_cyc(PDH_STD_US, CYC_PER_US) - 1);
    localparam logic [CW-1:0] C_PDH_O  = CW'(us_to_cyc(PDH_OD_US,  CYC_PER_US) - 1);
    localparam logic [CW-1:0] C_PDL_S  = CW'(us_to_cyc(PDL_STD_US, CYC_PER_US) - 1);
    localparam logic [CW-1:0] C_PDL_O  = CW'(us_to_cyc(PDL_OD_US,  CYC_PER_US) - 1);

    typedef struct packed {
        ow_state_e     st;
        logic [CW-1:0] cnt;
        logic          od;
        logic          rd;
        logic          pull;
        logic          rxv;
        logic          rxb;
        logic          txr;
        logic          rs;
        logic          rl;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [CW-1:0] samp_lim, hold_lim, rst_lim, pdh_lim, pdl_lim;

    // Speed latched in the state selects every limit
    assign samp_lim = fsm_q.od ? C_SAMP_O : C_SAMP_S;
    assign hold_lim = fsm_q.od ? C_HOLD_O : C_HOLD_S;
    assign rst_lim  = fsm_q.od ? C_RST_O  : C_RST_S;
    assign pdh_lim  = fsm_q.od ? C_PDH_O  : C_PDH_S;
    assign pdl_lim  = fsm_q.od ? C_PDL_O  : C_PDL_S;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.rxv = 1'b0;
        fsm_d.txr = 1'b0;
        fsm_d.rs  = 1'b0;
        fsm_d.rl  = 1'b0;
        if (fsm_q.cnt != '1) fsm_d.cnt = fsm_q.cnt + 1'b1;

        // Read-zero stretch ends a fixed time after the falling edge
        if (fsm_q.pull && (fsm_q.st == ST_SLOT || fsm_q.st == ST_LOW)
            && fsm_q.cnt == hold_lim)
            fsm_d.pull = 1'b0;

        case (fsm_q.st)
            ST_IDLE: begin
                fsm_d.cnt = '0;
                if (!line_m) begin
                    fsm_d.st   = ST_SLOT;
                    fsm_d.cnt  = {{(CW-1){1'b0}}, 1'b1};
                    fsm_d.od   = od_mode;
                    fsm_d.rd   = tx_en;
                    fsm_d.txr  = tx_en;
                    fsm_d.pull = tx_en & ~tx_bit;
                end
            end
            ST_SLOT: begin
                if (fsm_q.cnt == samp_lim) begin
                    if (!fsm_q.rd) begin
                        fsm_d.rxv = 1'b1;
                        fsm_d.rxb = line_s;
                    end
                    fsm_d.st = line_s ? ST_IDLE : ST_LOW;
                end
            end
            ST_LOW: begin
                if (line_s) begin
                    fsm_d.cnt = '0;
                    if (fsm_q.cnt >= rst_lim) begin
                        fsm_d.st = ST_PDH;
                        fsm_d.rl = (fsm_q.cnt >= C_LONG);
                        fsm_d.rs = (fsm_q.cnt <  C_LONG);
                        // Long reset falls back to standard timing
                        if (fsm_q.cnt >= C_LONG) fsm_d.od = 1'b0;
                    end else begin
                        fsm_d.st = ST_IDLE;
                    end
                end
            end
            ST_PDH: begin
                if (fsm_q.cnt == pdh_lim) begin
                    fsm_d.st   = ST_PDL;
                    fsm_d.cnt  = '0;
                    fsm_d.pull = 1'b1;
                end
            end
            ST_PDL: begin
                if (fsm_q.cnt == pdl_lim) begin
                    fsm_d.st   = ST_REC;
                    fsm_d.pull = 1'b0;
                end
            end
            ST_REC: begin
                // Wait for own pull-down release to be seen
                if (line_s) fsm_d.st = ST_IDLE;
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st   <= ST_IDLE;
            fsm_q.cnt  <= '0;
            fsm_q.od   <= 1'b0;
            fsm_q.rd   <= 1'b0;
            fsm_q.pull <= 1'b0;
            fsm_q.rxv  <= 1'b0;
            fsm_q.rxb  <= 1'b0;
            fsm_q.txr  <= 1'b0;
            fsm_q.rs   <= 1'b0;
            fsm_q.rl   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign pull_dn   = fsm_q.pull;
    assign rx_valid  = fsm_q.rxv;
    assign rx_bit    = fsm_q.rxb;
    assign tx_req    = fsm_q.txr;
    assign rst_short = fsm_q.rs;
    assign rst_long  = fsm_q.rl;

    // R2: received bits only come from write slots
    p_rx_write_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.rxv |-> !fsm_q.rd);

    // R3: a read request drives the pull-down from the latched bit
    p_txreq_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.txr |-> (fsm_q.pull == !$past(tx_bit)));

    // R6: a reset report starts the presence wait with the line released
    p_rst_presence_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.rs || fsm_q.rl) |-> (fsm_q.st == ST_PDH && !fsm_q.pull));

    // R6: recovery never drives the line
    p_rec_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_REC) |-> !fsm_q.pull);

    // R7: presence after a long reset runs at standard timing
    p_long_standard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.rl |-> !fsm_q.od);

    // R5: at most one reset class per cycle
    p_rst_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_short, rst_long}));
endmodule

// File: rtl/ow_bit_engine.sv
`timescale 1ns/1ps
module ow_bit_engine #(
    parameter int CYC_PER_US  = 100,
    parameter int HOLDOFF_NS  = 2000,
    parameter int SYNC_STAGES = 2,
    parameter int SAMP_STD_US = 30,
    parameter int SAMP_OD_US  = 3,
    parameter int HOLD_STD_US = 30,
    parameter int HOLD_OD_US  = 3,
    parameter int RST_STD_US  = 120,
    parameter int RST_OD_US   = 16,
    parameter int LONG_US     = 480,
    parameter int PDH_STD_US  = 20,
    parameter int PDH_OD_US   = 3,
    parameter int PDL_STD_US  = 120,
    parameter int PDL_OD_US   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_in,
    input  logic od_mode,
    input  logic tx_en,
    input  logic tx_bit,
    output logic pull_dn,
    output logic rx_valid,
    output logic rx_bit,
    output logic tx_req,
    output logic rst_short,
    output logic rst_long
);
    localparam int HOLD_CYC = ow_pkg::ns_to_cyc(HOLDOFF_NS, CYC_PER_US);

    logic line_s;
    logic line_m;

    ow_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (io_in),
        .dout  (line_s)
    );

    ow_holdoff #(
        .HOLD_CYC (HOLD_CYC)
    ) holdoff_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_s  (line_s),
        .od_mode (od_mode),
        .line_m  (line_m)
    );

    ow_slot_fsm #(
        .CYC_PER_US  (CYC_PER_US),
        .SAMP_STD_US (SAMP_STD_US),
        .SAMP_OD_US  (SAMP_OD_US),
        .HOLD_STD_US (HOLD_STD_US),
        .HOLD_OD_US  (HOLD_OD_US),
        .RST_STD_US  (RST_STD_US),
        .RST_OD_US   (RST_OD_US),
        .LONG_US     (LONG_US),
        .PDH_STD_US  (PDH_STD_US),
        .PDH_OD_US   (PDH_OD_US),
        .PDL_STD_US  (PDL_STD_US),
        .PDL_OD_US   (PDL_OD_US)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .line_m    (line_m),
        .od_mode   (od_mode),
        .tx_en     (tx_en),
        .tx_bit    (tx_bit),
        .pull_dn   (pull_dn),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .tx_req    (tx_req),
        .rst_short (rst_short),
        .rst_long  (rst_long)
    );
endmodule

// File: tb/ow_bit_engine_tb_top.sv
`timescale 1ns/1ps
module ow_bit_engine_tb_top;
    localparam int U = 4;   // cycles per microsecond in this bench

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic od_mode = 1'b0, tx_en = 1'b0, tx_bit = 1'b0;
    logic io_in;
    logic pull_dn, rx_valid, rx_bit, tx_req, rst_short, rst_long;

    always #2 clk = ~clk;

    // Wired-AND bus: master or slave pulling makes it low
    assign io_in = ~(m_low | pull_dn);

    ow_bit_engine #(.CYC_PER_US(U), .HOLDOFF_NS(2000)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_in(io_in), .od_mode(od_mode),
        .tx_en(tx_en), .tx_bit(tx_bit), .pull_dn(pull_dn), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .tx_req(tx_req), .rst_short(rst_short), .rst_long(rst_long));

    int checks = 0, errors = 0;
    int cyc = 0;
    int n_rx = 0, n_txr = 0, n_rs = 0, n_rl = 0, n_pull = 0, pull_rise = 0;
    logic last_rb = 1'b0, pull_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rx_valid) begin n_rx++; last_rb = rx_bit; end
        if (tx_req) n_txr++;
        if (rst_short) n_rs++;
        if (rst_long) n_rl++;
        if (pull_dn) n_pull++;
        if (pull_dn && !pull_prev) pull_rise = cyc;
        pull_prev = pull_dn;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    typedef struct packed {
        logic        od;
        logic        rd;
        logic        txb;
        logic        exp_rx;
        logic        exp_rb;
        logic [15:0] low;
        logic [15:0] tot;
        logic [15:0] pull;
    } vec_t;

    // Low and total times in cycles (U = 4 per microsecond)
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd24,  16'd320, 16'd0},   // std write-one
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd280, 16'd340, 16'd0},   // std write-zero
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd4,   16'd40,  16'd0},   // fast write-one
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd28,  16'd48,  16'd0},   // fast write-zero
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd8,   16'd320, 16'd120}, // std read-zero
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd8,   16'd320, 16'd0},   // std read-one
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd4,   16'd40,  16'd12},  // fast read-zero
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd4,   16'd40,  16'd0}    // fast read-one
    };

    task automatic slot(input logic od, input logic rd, input logic txb,
                        input int low, input int tot);
        od_mode = od; tx_en = rd; tx_bit = txb;
        m_low = 1'b1;
        tick(low);
        m_low = 1'b0;
        tick(tot - low);
        tx_en = 1'b0;
    endtask

    // Reset pulse followed by presence measurement
    task automatic bus_reset(input string tag, input logic od, input int low,
                             input int exp_long, input int exp_pdl, input int exp_dly);
        int s_rs, s_rl, s_pull, rel;
        s_rs = n_rs; s_rl = n_rl; s_pull = n_pull;
        od_mode = od; tx_en = 1'b0;
        m_low = 1'b1;
        tick(low);
        m_low = 1'b0;
        rel = cyc;
        tick(800);
        chk({tag, " long strobe"},  n_rl - s_rl, exp_long);
        chk({tag, " short strobe"}, n_rs - s_rs, 1 - exp_long);
        chk({tag, " presence length"}, n_pull - s_pull, exp_pdl);
        chk_rng({tag, " presence delay"}, pull_rise - rel, exp_dly - 1, exp_dly + 1);
    endtask

    initial begin
        int s_rx, s_txr, s_pull, s_rs, s_rl;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: quiet outputs after reset
        chk("R1 pull_dn after reset", int'(pull_dn), 0);
        chk("R1 strobes after reset", int'(rx_valid) + int'(tx_req) + int'(rst_short) + int'(rst_long), 0);

        // Table of slot vectors
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            v = VECS[i];
            s_rx = n_rx; s_txr = n_txr; s_pull = n_pull; s_rs = n_rs; s_rl = n_rl;
            slot(v.od, v.rd, v.txb, int'(v.low), int'(v.tot));
            if (v.rd) begin
                chk("R3 read slot tx_req", n_txr - s_txr, 1);
                chk("R3 read slot no rx", n_rx - s_rx, 0);
                chk("R3 read slot pull cycles", n_pull - s_pull, int'(v.pull));
            end else begin
                chk("R2 write slot rx count", n_rx - s_rx, int'(v.exp_rx));
                chk("R2 write slot bit", int'(last_rb), int'(v.exp_rb));
                chk("R2 write slot no tx_req", n_txr - s_txr, 0);
            end
            chk("R4 slot is no reset", (n_rs - s_rs) + (n_rl - s_rl), 0);
        end

        // R5 R6 R7: reset classes and presence timing
        bus_reset("R5 R6 std 500us",      1'b0, 2000, 1, 120 * U, 20 * U + 3);
        bus_reset("R6 R7 fast 50us",      1'b1, 200,  0, 12 * U,  3 * U + 3);
        bus_reset("R7 fast 500us",        1'b1, 2000, 1, 120 * U, 20 * U + 3);
        bus_reset("R5 fast 100us band",   1'b1, 400,  0, 12 * U,  3 * U + 3);
        bus_reset("R4 R7 std 200us",      1'b0, 800,  0, 120 * U, 20 * U + 3);

        // R4: 100us at standard speed is a write-zero, not a reset
        s_rx = n_rx; s_rs = n_rs; s_rl = n_rl;
        slot(1'b0, 1'b0, 1'b0, 400, 500);
        chk("R4 100us no reset", (n_rs - s_rs) + (n_rl - s_rl), 0);
        chk("R4 100us is write-zero rx", n_rx - s_rx, 1);
        chk("R4 100us bit", int'(last_rb), 0);

        // R8: glitch inside hold-off at standard speed is ignored
        s_rx = n_rx;
        od_mode = 1'b0;
        m_low = 1'b1; tick(280); m_low = 1'b0;
        tick(2); m_low = 1'b1; tick(2); m_low = 1'b0;
        tick(300);
        chk("R8 std glitch ignored rx count", n_rx - s_rx, 1);

        // R8: same glitch at fast speed starts a slot
        s_rx = n_rx;
        od_mode = 1'b1;
        m_low = 1'b1; tick(28); m_low = 1'b0;
        tick(2); m_low = 1'b1; tick(2); m_low = 1'b0;
        tick(60);
        chk("R8 fast glitch is slot rx count", n_rx - s_rx, 2);
        chk("R8 fast glitch bit", int'(last_rb), 1);

        // R8: fall after hold-off expiry at standard speed is a slot
        s_rx = n_rx;
        od_mode = 1'b0;
        m_low = 1'b1; tick(280); m_low = 1'b0;
        tick(20); m_low = 1'b1; tick(4); m_low = 1'b0;
        tick(300);
        chk("R8 late fall is slot rx count", n_rx - s_rx, 2);
        chk("R8 late fall bit", int'(last_rb), 1);

        // R6: presence pulse itself created no slot strobes
        s_rx = n_rx; s_txr = n_txr;
        bus_reset("R6 self-ignore", 1'b1, 200, 0, 12 * U, 3 * U + 3);
        chk("R6 no tx_req from presence", n_txr - s_txr, 0);
        chk_rng("R6 only the reset-slot rx", n_rx - s_rx, 0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule